// File: doc/BRIEF.md
# Tone Validation Steering Controller

This block is a clocked stand-in for the resistor-capacitor timing network that follows a dual-tone detector. The detector provides an early steering level, which is high while a valid tone pair is present, and a 4-bit code for that pair. The controller accepts a tone only after the early steering level has stayed high for a programmable validation time. On acceptance it captures the code and raises a guard output. After a short settling delay it raises a delayed steering flag and moves the captured code into the receive register that software reads.

Release is qualified the same way. The flag clears only after the early steering level has stayed low for a programmable interdigit pause. A short dropout inside a tone therefore does not end the digit, and a short burst of tone-like noise is never registered. A status word and an optional active-low interrupt report the flag. Pulsing the read strobe clears the pending interrupt.

Top module: `tone_steer_ctrl`

## Requirements
- R1: A code is registered only after `earlySteer` has been sampled high on VALID consecutive clock edges, where VALID = CLK_HZ/1e6 × VALID_US. A shorter high pulse leaves `rxData` and `dsFlag` unchanged, and the count restarts on the next high pulse.
- R2: On the registering edge, `codeIn` is captured and `guardOut` goes high.
- R3: `guardOut` stays high while `earlySteer` stays high. It falls on the first clock edge that samples `earlySteer` low.
- R4: `dsFlag` rises exactly SETTLE_CYC clock edges after the registering edge. It never rises on the registering edge itself.
- R5: `rxData` changes only on the edge where `dsFlag` rises, and then takes the captured code.
- R6: `dsFlag` clears only after `earlySteer` has been sampled low on PAUSE consecutive edges, where PAUSE = CLK_HZ/1e6 × PAUSE_US. Shorter low dropouts leave it set. No new code is registered while the flag is set.
- R7: When `intEnable` is 1, `irqN` is low from the rise of `dsFlag` until a `rdStrobe` pulse or until the flag clears. When `intEnable` is 0, `irqN` stays high.
- R8: `statusOut` bit 0 equals `dsFlag`. Bit 1 is the pending-interrupt bit, which is set at the flag rise and cleared by `rdStrobe` or by the flag clearing.
- R9: While `rstN` is low, `rxData`, `dsFlag`, `guardOut` and `statusOut` are 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| earlySteer | input | 1 | Tone-pair-present level from the detector |
| codeIn | input | 4 | Decoded tone-pair code |
| intEnable | input | 1 | Interrupt mode select |
| rdStrobe | input | 1 | One-cycle pulse when software reads the receive register |
| guardOut | output | 1 | Guard-time output |
| dsFlag | output | 1 | Delayed steering flag |
| rxData | output | 4 | Receive data register |
| statusOut | output | 2 | {pending interrupt, flag} |
| irqN | output | 1 | Active-low interrupt |

## Verification
The default build uses a 125 MHz clock and 40 ms windows, which is five million cycles per window. At that scale no bench could reach a window boundary. The bench therefore builds the block with CLK_HZ = 1 MHz, VALID_US = 8, PAUSE_US = 6 and SETTLE_CYC = 2. This gives windows of 8 and 6 cycles. With windows that short, pulses of exactly VALID and VALID−1 cycles can both be applied. So can dropouts one cycle shorter than the pause, and tones that arrive again while the flag is still set. The settle delay is visible cycle by cycle.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
  typedef enum logic [1:0] {
    ST_ACQ    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } steerState_t;

  typedef struct packed {
    logic latchCode;
    logic setFlag;
    logic clrFlag;
  } steerStrobe_t;
endpackage

// File: rtl/tone_steer_timer.sv
module tone_steer_timer
  import tone_steer_pkg::*;
#(
  parameter int VALID_CYC  = 8,
  parameter int PAUSE_CYC  = 8,
  parameter int SETTLE_CYC = 2,
  parameter int CW         = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         earlySteer,
  output steerStrobe_t strb
);
  localparam logic [CW-1:0] VALID_LAST  = CW'(VALID_CYC - 1);
  localparam logic [CW-1:0] PAUSE_LAST  = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  steerState_t stateQ, stateNxt;
  logic [CW-1:0] cntQ, cntNxt;

  always_comb begin
    stateNxt = stateQ;
    cntNxt   = cntQ;
    strb     = '0;
    case (stateQ)
      ST_ACQ: begin
        if (earlySteer) begin
          if (cntQ == VALID_LAST) begin
            strb.latchCode = 1'b1;
            stateNxt       = ST_SETTLE;
            cntNxt         = '0;
          end else begin
            cntNxt = cntQ + 1'b1;
          end
        end else begin
          cntNxt = '0;
        end
      end
      ST_SETTLE: begin
        if (cntQ == SETTLE_LAST) begin
          strb.setFlag = 1'b1;
          stateNxt     = ST_HOLD;
          cntNxt       = '0;
        end else begin
          cntNxt = cntQ + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!earlySteer) begin
          if (cntQ == PAUSE_LAST) begin
            strb.clrFlag = 1'b1;
            stateNxt     = ST_ACQ;
            cntNxt       = '0;
          end else begin
            cntNxt = cntQ + 1'b1;
          end
        end else begin
          cntNxt = '0;
        end
      end
      default: begin
        stateNxt = ST_ACQ;
        cntNxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_ACQ;
      cntQ   <= '0;
    end else begin
      stateQ <= stateNxt;
      cntQ   <= cntNxt;
    end
  end

  // R1: registration needs the level high on the previous edge as well
  p_acq_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchCode && VALID_CYC > 1) |-> $past(earlySteer));

  // R6: release needs the level low on the previous edge as well
  p_pause_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && PAUSE_CYC > 1) |-> !$past(earlySteer));
endmodule

// File: rtl/tone_steer_data.sv
module tone_steer_data
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              earlySteer,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              intEnable,
  input  logic              rdStrobe,
  input  steerStrobe_t      strb,
  output logic              guardOut,
  output logic              dsFlag,
  output logic [CODE_W-1:0] rxData,
  output logic [1:0]        statusOut,
  output logic              irqN
);
  logic [CODE_W-1:0] holdQ, rxQ;
  logic flagQ, guardQ, pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ  <= '0;
      rxQ    <= '0;
      flagQ  <= 1'b0;
      guardQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      if (strb.latchCode) holdQ <= codeIn;
      if (strb.setFlag) rxQ <= holdQ;

      if (strb.setFlag)      flagQ <= 1'b1;
      else if (strb.clrFlag) flagQ <= 1'b0;

      if (strb.latchCode) guardQ <= 1'b1;
      else                guardQ <= guardQ & earlySteer;

      if (strb.setFlag)                    pendQ <= 1'b1;
      else if (rdStrobe || strb.clrFlag)   pendQ <= 1'b0;
    end
  end

  assign guardOut  = guardQ;
  assign dsFlag    = flagQ;
  assign rxData    = rxQ;
  assign statusOut = {pendQ, flagQ};
  assign irqN      = ~(intEnable & pendQ);

  // R2: guard only rises right after a registration strobe
  p_guard_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardQ) |-> $past(strb.latchCode));

  // R4: flag never rises on the registering edge
  p_flag_delayed_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> !$past(strb.latchCode));

  // R5: receive register moves only with the flag rise
  p_rx_on_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxQ) |-> $rose(flagQ));

  // R7: interrupt never asserted without the flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> flagQ);
endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
  import tone_steer_pkg::*;
#(
  parameter longint CLK_HZ     = 125_000_000,
  parameter longint VALID_US   = 40_000,
  parameter longint PAUSE_US   = 40_000,
  parameter int     SETTLE_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       earlySteer,
  input  logic [3:0] codeIn,
  input  logic       intEnable,
  input  logic       rdStrobe,
  output logic       guardOut,
  output logic       dsFlag,
  output logic [3:0] rxData,
  output logic [1:0] statusOut,
  output logic       irqN
);
  localparam int VALID_CYC = int'((CLK_HZ / 1_000_000) * VALID_US);
  localparam int PAUSE_CYC = int'((CLK_HZ / 1_000_000) * PAUSE_US);
  localparam int MAX_A     = (VALID_CYC > PAUSE_CYC) ? VALID_CYC : PAUSE_CYC;
  localparam int MAX_CYC   = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  steerStrobe_t strb;

  tone_steer_timer #(
    .VALID_CYC (VALID_CYC),
    .PAUSE_CYC (PAUSE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CW        (CW)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .earlySteer(earlySteer),
    .strb      (strb)
  );

  tone_steer_data #(
    .CODE_W(4)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .earlySteer(earlySteer),
    .codeIn    (codeIn),
    .intEnable (intEnable),
    .rdStrobe  (rdStrobe),
    .strb      (strb),
    .guardOut  (guardOut),
    .dsFlag    (dsFlag),
    .rxData    (rxData),
    .statusOut (statusOut),
    .irqN      (irqN)
  );
endmodule

// File: tb/test_tone_steer_ctrl.sv
module test_tone_steer_ctrl;
  localparam int VCYC = 8;
  localparam int PCYC = 6;
  localparam int SCYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic earlySteer = 1'b0;
  logic [3:0] codeIn = '0;
  logic intEnable = 1'b0;
  logic rdStrobe = 1'b0;
  logic guardOut, dsFlag, irqN;
  logic [3:0] rxData;
  logic [1:0] statusOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tone_steer_ctrl #(
    .CLK_HZ(1_000_000), .VALID_US(VCYC), .PAUSE_US(PCYC), .SETTLE_CYC(SCYC)
  ) i_tone_steer_ctrl (
    .clk(clk), .rstN(rstN), .earlySteer(earlySteer), .codeIn(codeIn),
    .intEnable(intEnable), .rdStrobe(rdStrobe), .guardOut(guardOut),
    .dsFlag(dsFlag), .rxData(rxData), .statusOut(statusOut), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // code, high cycles, low cycles, expected rxData, expected flag
  typedef struct packed {
    logic [3:0] code;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [3:0] expRx;
    logic       expFlag;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h5, 8'd12, 8'd10, 4'h5, 1'b0},  // R1 R5 long tone registers
    '{4'h9, 8'd5,  8'd10, 4'h5, 1'b0},  // R1 short pulse rejected
    '{4'hA, 8'd8,  8'd10, 4'hA, 1'b0},  // R1 exactly VALID cycles
    '{4'h7, 8'd7,  8'd10, 4'hA, 1'b0},  // R1 one cycle short
    '{4'h0, 8'd20, 8'd3,  4'h0, 1'b1},  // R6 pause too short, flag stays
    '{4'h3, 8'd20, 8'd10, 4'h0, 1'b0}   // R6 no re-registration while set
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitn(3);
    // R9 reset state
    chk("R9 rxData", {4'h0, rxData}, 8'h00);
    chk("R9 flags", {4'h0, irqN, guardOut, statusOut}, 8'h08);
    rstN = 1'b1;
    waitn(2);

    for (int i = 0; i < 6; i++) begin
      codeIn = VECS[i].code;
      earlySteer = 1'b1;
      waitn(int'(VECS[i].hi));
      earlySteer = 1'b0;
      waitn(int'(VECS[i].lo));
      chk("R1/R5/R6 vector rx", {4'h0, rxData}, {4'h0, VECS[i].expRx});
      chk("R6 vector flag", {7'h0, dsFlag}, {7'h0, VECS[i].expFlag});
    end
    waitn(10);  // let entry 5 state settle (flag cleared by entry 6)

    // Directed: cycle-by-cycle registration with interrupts on
    intEnable = 1'b1;
    codeIn = 4'hC;
    earlySteer = 1'b1;
    waitn(VCYC - 1);
    chk("R2 guard not yet", {7'h0, guardOut}, 8'h00);
    waitn(1);
    chk("R2 guard at registration", {7'h0, guardOut}, 8'h01);
    chk("R4 flag not with latch", {7'h0, dsFlag}, 8'h00);
    chk("R5 rx not yet updated", {4'h0, rxData}, 8'h00);
    codeIn = 4'h1;  // code change after latch must not leak in
    waitn(SCYC - 1);
    chk("R4 flag one early", {7'h0, dsFlag}, 8'h00);
    waitn(1);
    chk("R4 flag after settle", {7'h0, dsFlag}, 8'h01);
    chk("R5 rx takes latched code", {4'h0, rxData}, 8'h0C);
    chk("R7 irq asserted", {7'h0, irqN}, 8'h00);
    chk("R8 status", {6'h0, statusOut}, 8'h03);
    rdStrobe = 1'b1;
    waitn(1);
    rdStrobe = 1'b0;
    chk("R7 read clears irq", {7'h0, irqN}, 8'h01);
    chk("R8 status after read", {6'h0, statusOut}, 8'h01);
    chk("R3 guard held with tone", {7'h0, guardOut}, 8'h01);
    // R6 dropout shorter than the pause
    earlySteer = 1'b0;
    waitn(1);
    chk("R3 guard drops with tone", {7'h0, guardOut}, 8'h00);
    waitn(PCYC - 2);
    earlySteer = 1'b1;
    waitn(3);
    chk("R6 dropout ignored", {7'h0, dsFlag}, 8'h01);
    chk("R3 guard stays off after dropout", {7'h0, guardOut}, 8'h00);
    earlySteer = 1'b0;
    waitn(PCYC - 1);
    chk("R6 flag held one short", {7'h0, dsFlag}, 8'h01);
    waitn(1);
    chk("R6 flag clears at pause", {7'h0, dsFlag}, 8'h00);
    chk("R5 rx kept after release", {4'h0, rxData}, 8'h0C);

    // R7 interrupt clears with flag when not read; R7 disabled mode
    codeIn = 4'hD;
    earlySteer = 1'b1;
    waitn(VCYC + SCYC);
    chk("R7 irq again", {7'h0, irqN}, 8'h00);
    intEnable = 1'b0;
    waitn(1);
    chk("R7 irq off when disabled", {7'h0, irqN}, 8'h01);
    chk("R8 pending kept", {6'h0, statusOut}, 8'h03);
    intEnable = 1'b1;
    earlySteer = 1'b0;
    waitn(PCYC + 1);
    chk("R7 irq cleared by release", {7'h0, irqN}, 8'h01);
    chk("R8 status cleared", {6'h0, statusOut}, 8'h00);

    // R9 reset mid-digit
    earlySteer = 1'b1;
    waitn(VCYC + SCYC + 1);
    rstN = 1'b0;
    waitn(1);
    chk("R9 reset clears", {1'b0, irqN, guardOut, dsFlag, rxData}, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule